// File: doc/BRIEF.md
# Byte-Addressed Load/Store Unit

This block is the memory stage of a simple integer pipeline. Each cycle it may accept one request made of a base register value, a signed 16-bit displacement, a store operand and an operation code. It adds the sign-extended displacement to the base to form a byte address and checks that word accesses are aligned. It then reads or writes a small internal data memory. The memory holds 256 words of four bytes each, and addresses step by one per byte, so neighbouring words are four addresses apart.

A load returns its 32-bit result on the clock edge after the request, with a single-cycle valid strobe. A byte load takes one of the four lanes of the addressed word, big-endian, and sign-extends it. A byte store changes only its own lane. A word request whose address is not a multiple of four is dropped: memory stays as it was, no load data is returned, and a fault flag pulses for one cycle.

Top module: `lsu_top`

## Requirements
- R1: The byte address is `base + sign_extend(disp)` modulo 2^32, so the displacement spans -32768 to 32767. The word selected is address bits [9:2], and address bits [31:10] have no effect.
- R2: Operation code 2'b00 is a word load. An accepted aligned word load raises `ld_valid` for exactly one cycle after the request edge and presents the addressed 32-bit word on `ld_data` in that cycle.
- R3: Operation code 2'b01 is a word store. An aligned word store writes all four bytes of `st_data` and raises neither `ld_valid` nor `fault`.
- R4: Byte lanes are big-endian. Address bits [1:0] = 0 select word bits [31:24], 1 selects [23:16], 2 selects [15:8] and 3 selects [7:0].
- R5: Operation code 2'b10 is a byte load. It returns the selected byte sign-extended to 32 bits, with the same timing as R2.
- R6: Operation code 2'b11 is a byte store. It writes `st_data[7:0]` into the addressed lane only and leaves the other three bytes of that word unchanged.
- R7: A word load or store whose address bits [1:0] are not zero raises `fault` for exactly one cycle after the request edge. It does not raise `ld_valid` and does not change memory.
- R8: Byte loads and stores never raise `fault`, at any address offset.
- R9: After reset, and in any cycle without a returned load, `ld_valid` and `fault` are 0 and `ld_data` is 0.
- R10: While `req_valid` is 0, the other request inputs have no effect on memory or on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 word load, 01 word store, 10 byte load, 11 byte store |
| base | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| st_data | input | 32 | Store operand (byte store uses bits 7:0) |
| ld_valid | output | 1 | One-cycle strobe marking returned load data |
| ld_data | output | 32 | Load result, zero when ld_valid is low |
| fault | output | 1 | One-cycle misaligned word access flag |

## Verification
The checker watches timing and exclusivity on every cycle. It checks that `fault` follows exactly the misaligned word requests and that `ld_valid` follows exactly the accepted loads. It also checks that the two strobes never coincide, that byte requests never fault, that byte loads come back sign-extended and that `ld_data` is zero when idle. Data values can only be shown by the bench's scenarios, which compare against a byte-level model. These cover lane order, the untouched lanes after a byte store, the address wrap above the 256-word range, the extreme displacements, and memory left unchanged after faulting or idle requests.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int XLEN   = 32;
    localparam int DISP_W = 16;
    localparam int BYTES  = XLEN / 8;
    localparam int OFF_W  = $clog2(BYTES);

    // op[0] = store, op[1] = byte width
    typedef enum logic [1:0] {
        LSU_LW = 2'b00,
        LSU_SW = 2'b01,
        LSU_LB = 2'b10,
        LSU_SB = 2'b11
    } lsu_op_e;

    typedef struct packed {
        logic            go;       // access proceeds to memory
        logic            store;
        logic            is_byte;
        logic [XLEN-1:0] ea;
    } lsu_acc_t;

    function automatic logic [XLEN-1:0] sext_disp(input logic [DISP_W-1:0] d);
        return {{(XLEN-DISP_W){d[DISP_W-1]}}, d};
    endfunction

    function automatic logic op_is_store(input lsu_op_e op);
        return op[0];
    endfunction

    function automatic logic op_is_byte(input lsu_op_e op);
        return op[1];
    endfunction

    // big-endian: offset 0 lives in the most significant lane
    function automatic logic [OFF_W-1:0] lane_of(input logic [OFF_W-1:0] off);
        return OFF_W'(BYTES - 1) - off;
    endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
    import lsu_pkg::*;
(
    input  logic              req_valid,
    input  lsu_op_e           req_op,
    input  logic [XLEN-1:0]   base,
    input  logic [DISP_W-1:0] disp,
    output lsu_acc_t          acc,
    output logic              misalign
);
    logic [XLEN-1:0] ea;
    logic            bad_word;

    always_comb begin
        ea       = base + sext_disp(disp);
        bad_word = !op_is_byte(req_op) && (ea[OFF_W-1:0] != '0);
        misalign = req_valid && bad_word;
        acc.go      = req_valid && !bad_word;
        acc.store   = op_is_store(req_op);
        acc.is_byte = op_is_byte(req_op);
        acc.ea      = ea;
    end
endmodule

// File: rtl/lsu_stlane.sv
module lsu_stlane
    import lsu_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    input  logic             is_byte,
    input  logic [XLEN-1:0]  st_data,
    output logic [XLEN-1:0]  wr_word,
    output logic [BYTES-1:0] wr_be
);
    logic [OFF_W-1:0] sel;
    assign sel = lane_of(off);

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign wr_word[g*8 +: 8] = is_byte ? st_data[7:0] : st_data[g*8 +: 8];
        assign wr_be[g]          = !is_byte || (sel == OFF_W'(g));
    end
endmodule

// File: rtl/lsu_ldfmt.sv
module lsu_ldfmt
    import lsu_pkg::*;
(
    input  logic             valid,
    input  logic             is_byte,
    input  logic [OFF_W-1:0] off,
    input  logic [XLEN-1:0]  raw,
    output logic [XLEN-1:0]  data
);
    logic [7:0] pick;

    always_comb begin
        pick = raw[lane_of(off)*8 +: 8];
        if (!valid)
            data = '0;
        else if (is_byte)
            data = {{(XLEN-8){pick[7]}}, pick};
        else
            data = raw;
    end
endmodule

// File: rtl/lsu_mem.sv
module lsu_mem
    import lsu_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic             re,
    input  logic [BYTES-1:0] be,
    input  logic [IDX_W-1:0] idx,
    input  logic [XLEN-1:0]  wdata,
    output logic [XLEN-1:0]  rdata
);
    for (genvar g = 0; g < BYTES; g++) begin : g_bank
        logic [7:0] bank [DEPTH];
        logic [7:0] q;

        always_ff @(posedge clk) begin
            if (we && be[g])
                bank[idx] <= wdata[g*8 +: 8];
            if (re)
                q <= bank[idx];
        end

        assign rdata[g*8 +: 8] = q;
    end
endmodule

// File: rtl/lsu_top.sv
module lsu_top
    import lsu_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [1:0]  req_op,
    input  logic [31:0] base,
    input  logic [15:0] disp,
    input  logic [31:0] st_data,
    output logic        ld_valid,
    output logic [31:0] ld_data,
    output logic        fault
);
    localparam int IDX_W = $clog2(DEPTH);

    lsu_acc_t         acc;
    logic             misalign;
    logic [XLEN-1:0]  wr_word;
    logic [BYTES-1:0] wr_be;
    logic [XLEN-1:0]  raw;
    logic             do_wr, do_rd;
    logic [IDX_W-1:0] idx;
    logic [OFF_W-1:0] off_q;
    logic             byte_q;

    lsu_agen u_agen (
        .req_valid (req_valid),
        .req_op    (lsu_op_e'(req_op)),
        .base      (base),
        .disp      (disp),
        .acc       (acc),
        .misalign  (misalign)
    );

    lsu_stlane u_stlane (
        .off     (acc.ea[OFF_W-1:0]),
        .is_byte (acc.is_byte),
        .st_data (st_data),
        .wr_word (wr_word),
        .wr_be   (wr_be)
    );

    assign do_wr = acc.go && acc.store;
    assign do_rd = acc.go && !acc.store;
    assign idx   = acc.ea[OFF_W +: IDX_W];

    lsu_mem #(.DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (do_wr),
        .re    (do_rd),
        .be    (wr_be),
        .idx   (idx),
        .wdata (wr_word),
        .rdata (raw)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_valid <= 1'b0;
            fault    <= 1'b0;
            off_q    <= '0;
            byte_q   <= 1'b0;
        end else begin
            ld_valid <= do_rd;
            fault    <= misalign;
            if (do_rd) begin
                off_q  <= acc.ea[OFF_W-1:0];
                byte_q <= acc.is_byte;
            end
        end
    end

    lsu_ldfmt u_ldfmt (
        .valid   (ld_valid),
        .is_byte (byte_q),
        .off     (off_q),
        .raw     (raw),
        .data    (ld_data)
    );
endmodule

// File: rtl/lsu_chk.sv
module lsu_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [1:0]  req_op,
    input logic [31:0] base,
    input logic [15:0] disp,
    input logic        ld_valid,
    input logic [31:0] ld_data,
    input logic        fault
);
    logic [1:0] low_ea;
    logic       word_bad, load_ok;

    assign low_ea   = base[1:0] + disp[1:0];
    assign word_bad = req_valid && !req_op[1] && (low_ea != 2'b00);
    assign load_ok  = req_valid && !req_op[0] && (req_op[1] || low_ea == 2'b00);

    p_fault_tracks_r7: assert property (@(posedge clk) disable iff (rst)
        word_bad |=> fault);

    p_fault_cause_r7: assert property (@(posedge clk) disable iff (rst)
        !word_bad |=> !fault);

    p_valid_tracks_r2: assert property (@(posedge clk) disable iff (rst)
        load_ok |=> ld_valid);

    p_valid_cause_r10: assert property (@(posedge clk) disable iff (rst)
        !load_ok |=> !ld_valid);

    p_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(fault && ld_valid));

    p_byte_nofault_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op[1]) |=> !fault);

    p_lb_sext_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'b10) |=> (ld_data[31:8] == {24{ld_data[7]}}));

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !ld_valid |-> (ld_data == 32'h0));
endmodule

bind lsu_top lsu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .base      (base),
    .disp      (disp),
    .ld_valid  (ld_valid),
    .ld_data   (ld_data),
    .fault     (fault)
);

// File: tb/lsu_top_test.sv
module lsu_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [31:0] base = '0;
    logic [15:0] disp = '0;
    logic [31:0] st_data = '0;
    logic        ld_valid;
    logic [31:0] ld_data;
    logic        fault;

    always #10 clk = ~clk;   // 50 MHz

    lsu_top uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .base(base), .disp(disp), .st_data(st_data),
        .ld_valid(ld_valid), .ld_data(ld_data), .fault(fault)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] mdl [1024];
    logic        g_valid, g_fault;
    logic [31:0] g_data;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ea_of(input logic [31:0] b, input logic [15:0] d);
        return b + {{16{d[15]}}, d};
    endfunction

    function automatic logic [31:0] mword(input logic [31:0] a);
        logic [9:0] i;
        i = {a[9:2], 2'b00};
        return {mdl[i], mdl[i+1], mdl[i+2], mdl[i+3]};
    endfunction

    // drive at a falling edge, sample at the next falling edge
    task automatic op(input logic v, input logic [1:0] o, input logic [31:0] b,
                      input logic [15:0] d, input logic [31:0] sd);
        logic [31:0] a;
        req_valid = v; req_op = o; base = b; disp = d; st_data = sd;
        @(negedge clk);
        g_valid = ld_valid; g_data = ld_data; g_fault = fault;
        req_valid = 1'b0;
        a = ea_of(b, d);
        if (v) begin
            if (o == 2'b01 && a[1:0] == 2'b00) begin
                mdl[{a[9:2],2'b00}]   = sd[31:24];
                mdl[{a[9:2],2'b01}]   = sd[23:16];
                mdl[{a[9:2],2'b10}]   = sd[15:8];
                mdl[{a[9:2],2'b11}]   = sd[7:0];
            end else if (o == 2'b11) begin
                mdl[a[9:0]] = sd[7:0];
            end
        end
    endtask

    task automatic load_word_check(input logic [31:0] b, input logic [15:0] d, input string tag);
        logic [31:0] e;
        e = mword(ea_of(b, d));
        op(1'b1, 2'b00, b, d, 32'h0);
        chk(g_valid === 1'b1 && g_fault === 1'b0, {tag, " valid"}, {30'h0, g_fault, g_valid}, 32'h1);
        chk(g_data === e, tag, g_data, e);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] b, a, e;
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(ld_valid === 1'b0 && fault === 1'b0, "R9 reset strobes", {30'h0, fault, ld_valid}, 32'h0);
        chk(ld_data === 32'h0, "R9 reset data", ld_data, 32'h0);

        // R3 R1 fill every word, varying displacement sign and upper address bits
        for (int i = 0; i < 256; i++) begin
            d = 16'(i * 997);
            b = 32'(i * 4) + (32'(i) << 12) - {{16{d[15]}}, d};
            op(1'b1, 2'b01, b, d, (32'(i) * 32'h01030507) ^ 32'h96C3A50F);
            chk(g_valid === 1'b0 && g_fault === 1'b0 && g_data === 32'h0, "R3 store quiet",
                {30'h0, g_fault, g_valid}, 32'h0);
        end
        // R2 R1 read back via different decomposition
        for (int i = 0; i < 256; i++)
            load_word_check(32'(i * 4) + 32'h0000_0405 + 32'hFFFF_F000, 16'hFBFB, "R2 R1 word load");

        // R1 extreme displacements
        load_word_check(32'h0001_0000, 16'h8000, "R1 disp -32768");
        load_word_check(32'h1000_0001, 16'h7FFF, "R1 disp 32767");
        load_word_check(32'hFFFF_FFFC, 16'h0008, "R1 wrap 2^32");

        // R4 R5 byte loads of every byte
        for (int i = 0; i < 1024; i++) begin
            e = {{24{mdl[i][7]}}, mdl[i]};
            op(1'b1, 2'b10, 32'(i) + 32'h0055_0000, 16'h0000, 32'h0);
            chk(g_valid === 1'b1 && g_fault === 1'b0, "R8 R5 byte load strobe", {30'h0, g_fault, g_valid}, 32'h1);
            chk(g_data === e, "R4 R5 byte load", g_data, e);
        end

        // R6 byte stores over every byte, word readback back-to-back
        for (int i = 0; i < 1024; i++) begin
            op(1'b1, 2'b11, 32'(i) + 32'h10, 16'hFFF0, {24'hABCDEF, 8'(i * 29 + 128)});
            chk(g_fault === 1'b0 && g_valid === 1'b0, "R8 R6 byte store quiet", {30'h0, g_fault, g_valid}, 32'h0);
            load_word_check(32'(i & ~3), 16'h0, "R6 byte store lanes");
        end

        // R7 misaligned word requests
        for (int i = 0; i < 64; i++) begin
            for (int k = 1; k < 4; k++) begin
                a = 32'(i * 16 + k);
                op(1'b1, 2'b01, a, 16'h0, 32'hDEAD_BEEF);
                chk(g_fault === 1'b1 && g_valid === 1'b0, "R7 store fault", {30'h0, g_fault, g_valid}, 32'h2);
                op(1'b1, 2'b00, a - 32'd1, 16'h0001, 32'h0);
                chk(g_fault === 1'b1 && g_valid === 1'b0 && g_data === 32'h0, "R7 load fault",
                    {30'h0, g_fault, g_valid}, 32'h2);
                @(negedge clk);
                chk(fault === 1'b0, "R7 fault one cycle", {31'h0, fault}, 32'h0);
                load_word_check(a & ~32'h3, 16'h0, "R7 memory unchanged");
            end
        end

        // R10 idle requests have no effect
        for (int i = 0; i < 32; i++) begin
            op(1'b0, 2'(i), 32'(i * 8), 16'h0, 32'h1234_5678);
            chk(g_valid === 1'b0 && g_fault === 1'b0 && g_data === 32'h0, "R10 idle outputs",
                {30'h0, g_fault, g_valid}, 32'h0);
            load_word_check(32'(i * 8), 16'h0, "R10 idle memory");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule